// File: doc/BRIEF.md
# Serial Bus Master Sequencer

This block is a synchronous serial master. It drives a serial clock, one bidirectional data line and two active-low slave selects. Software sets up a transfer through a small word-addressed register interface: target slave, select lead and lag, clock divisor, per-slave edge choices and the data word. A write to the transfer-control word starts the transfer. The sequencer then asserts the chosen select and waits the lead time. It runs the clock for the requested number of bits while shifting data MSB first, stops the clock, waits the lag time and releases the select.

Reads and writes each shift on an edge chosen per slave. For a read, the master leaves the data line undriven so that the slave can drive it. The received bits land right-aligned in the data buffer. The data line and the clock can each be set to push-pull or open-drain through their output enables. In open-drain mode a pin is driven only low and is released for high.

Top module: `sbm_master`

## Requirements
- R1: After reset, both selects are high, the serial clock is low and driven, the data line is undriven, and the status and buffer words read 0.
- R2: Registers are 32-bit words. Offset 0x00 is config, with slave code [2:0], lead [4:3], lag [6:5], data open-drain [8] and clock open-drain [9]. Offset 0x04 is transfer control, with bit count minus one [4:0] and read [8]. Offset 0x08 is mode, with half-period minus one [7:0]. Offsets 0x10 and 0x14 hold the settings of slave 0 and slave 1: read on falling edge [0] and write on falling edge [1]. Offset 0x30 is status, with busy [0]. Offset 0x38 is the data buffer. Unused bits and unmapped offsets read 0.
- R3: Slave code 0 asserts ss_n_o[0] and code 1 asserts ss_n_o[1]. Codes 2 to 7 assert no select but still run the transfer. At most one select is ever low.
- R4: With P = 2*(mode+1) system clocks, the first rising clock edge comes (lead+1)*P + P/2 cycles after the select falls.
- R5: The select rises (lag+1)*P cycles after the last falling clock edge.
- R6: A transfer of n bits gives exactly n clock pulses with a rise-to-rise period of P. The clock is low whenever no select is asserted.
- R7: A write sends buffer bits [n-1:0] MSB first. When the slave's write-falling bit is 1, each bit is valid at the rising edge. When it is 0, each bit changes on the rising edge and is valid at the falling edge.
- R8: A read never enables the data driver. It samples on the falling edge when the slave's read-falling bit is 1, and on the rising edge otherwise. The buffer then holds the n bits right-aligned, with zeros above.
- R9: Busy reads 1 from the start write until the select is released. Transfer-control writes while busy are ignored and leave the control word unchanged.
- R10: With data open-drain set, the data line is never driven high.
- R11: With clock open-drain set, the clock pin is never driven high. It is released for high and driven low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational on addr_i |
| sclk_o | output | 1 | Serial clock output value |
| sclk_oe_o | output | 1 | Serial clock output enable |
| sdio_o | output | 1 | Data line output value |
| sdio_oe_o | output | 1 | Data line output enable |
| sdio_i | input | 1 | Data line input |
| ss_n_o | output | 2 | Slave selects, active low |

## Verification
The assertions check the following on every cycle: at most one select is low, a reserved code asserts no select, the data driver stays off during reads, and neither open-drain pin ever drives high. They also check that the clock stays low outside the run phase, that the divider counter stays within its bound, and that control writes during a transfer leave the latched control word unchanged. Only the bench scenarios can show the rest. That covers the exact lead and lag distances in cycles, the clock period and pulse count, MSB-first bit order under each edge choice, and right-aligned read data for bit counts from 1 to 32.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_LAG  = 2'd3
  } seq_st_e;

  localparam int unsigned OFF_CFG  = 32'h00;
  localparam int unsigned OFF_CTRL = 32'h04;
  localparam int unsigned OFF_MODE = 32'h08;
  localparam int unsigned OFF_SLV0 = 32'h10;
  localparam int unsigned OFF_STAT = 32'h30;
  localparam int unsigned OFF_BUF  = 32'h38;

  localparam int CFG_LEAD_LSB = 3;
  localparam int CFG_LAG_LSB  = 5;
  localparam int CFG_SDOD_BIT = 8;
  localparam int CFG_SCOD_BIT = 9;
  localparam int CTRL_RD_BIT  = 8;
endpackage

// File: rtl/sbm_clkdiv.sv
module sbm_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4: half-period counter never passes its limit
  p_div_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= half_i);
endmodule

// File: rtl/sbm_seq.sv
module sbm_seq import sbm_pkg::*; #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [1:0]       lead_i,
  input  logic [1:0]       lag_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             busy_o,
  output logic             run_o,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             launch0_o,
  output logic             done_o
);
  seq_st_e          st_q;
  logic [2:0]       ph_q;
  logic [CNT_W-1:0] bcnt_q;
  logic             sclk_q;

  assign busy_o    = (st_q != ST_IDLE);
  assign run_o     = (st_q == ST_RUN);
  assign sclk_o    = sclk_q;
  assign rise_o    = run_o && tick_i && !sclk_q;
  assign fall_o    = run_o && tick_i && sclk_q;
  assign launch0_o = (st_q == ST_LEAD) && tick_i && (ph_q == {lead_i, 1'b1});
  assign done_o    = fall_o && (bcnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      bcnt_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_LEAD;
          ph_q   <= '0;
          bcnt_q <= '0;
        end
        ST_LEAD: if (tick_i) begin
          if (ph_q == {lead_i, 1'b1}) begin
            st_q <= ST_RUN;
            ph_q <= '0;
          end else ph_q <= ph_q + 1'b1;
        end
        ST_RUN: if (tick_i) begin
          sclk_q <= ~sclk_q;
          if (sclk_q) begin
            if (bcnt_q == last_i) st_q <= ST_LAG;
            else                  bcnt_q <= bcnt_q + 1'b1;
          end
        end
        ST_LAG: if (tick_i) begin
          if (ph_q == {lag_i, 1'b1}) st_q <= ST_IDLE;
          else                       ph_q <= ph_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_clk_idle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != ST_RUN |-> !sclk_q);
  p_bits_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_RUN |-> bcnt_q <= last_i);
  p_lag_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (st_q == ST_LAG) && !sclk_q);
endmodule

// File: rtl/sbm_shift.sv
module sbm_shift #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [CNT_W-1:0]  last_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              launch0_i,
  input  logic              wr_fall_i,
  input  logic              rd_fall_i,
  input  logic              sdi_i,
  output logic              out_bit_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [DATA_W-1:0] tx_q;
  logic              wr_edge, rd_edge;

  // falling-edge writers present the first bit as the clock starts
  assign wr_edge = wr_fall_i ? (fall_i || launch0_i) : rise_i;
  assign rd_edge = rd_fall_i ? fall_i : rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q      <= '0;
      rx_o      <= '0;
      out_bit_o <= 1'b0;
    end else if (load_i) begin
      tx_q      <= tx_data_i << (CNT_W'(DATA_W - 1) - last_i);
      rx_o      <= '0;
      out_bit_o <= 1'b0;
    end else begin
      if (wr_edge) begin
        out_bit_o <= tx_q[DATA_W-1];
        tx_q      <= tx_q << 1;
      end
      if (rd_edge) rx_o <= {rx_o[DATA_W-2:0], sdi_i};
    end
  end
endmodule

// File: rtl/sbm_master.sv
module sbm_master import sbm_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 8,
  parameter int NSLV   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  input  logic              sdio_i,
  output logic [NSLV-1:0]   ss_n_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int SEL_W = 3;

  logic [SEL_W-1:0]  cfg_tgt, a_tgt;
  logic [1:0]        cfg_lead, cfg_lag, a_lead, a_lag;
  logic              cfg_sdod, cfg_scod;
  logic [CNT_W-1:0]  ctrl_last;
  logic              ctrl_rd;
  logic [DIV_W-1:0]  mode_half, a_half;
  logic [NSLV-1:0]   slv_rdf, slv_wrf;
  logic              a_rdf, a_wrf, rdf_pick, wrf_pick;
  logic [DATA_W-1:0] buf_q, rx;
  logic              wr_cfg, wr_ctrl, wr_mode, wr_buf, start, done_q;
  logic              busy, run, sclk_q, tick, rise, fall, launch0, done, out_bit;

  assign wr_cfg  = wr_en_i && (addr_i == ADDR_W'(OFF_CFG));
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign wr_mode = wr_en_i && (addr_i == ADDR_W'(OFF_MODE));
  assign wr_buf  = wr_en_i && (addr_i == ADDR_W'(OFF_BUF));
  assign start   = wr_ctrl && !busy;

  always_comb begin
    rdf_pick = 1'b0;
    wrf_pick = 1'b0;
    for (int i = 0; i < NSLV; i++) begin
      if (cfg_tgt == SEL_W'(i)) begin
        rdf_pick = slv_rdf[i];
        wrf_pick = slv_wrf[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_tgt   <= '0;
      cfg_lead  <= '0;
      cfg_lag   <= '0;
      cfg_sdod  <= 1'b0;
      cfg_scod  <= 1'b0;
      mode_half <= '0;
      slv_rdf   <= '0;
      slv_wrf   <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_tgt  <= wdata_i[SEL_W-1:0];
        cfg_lead <= wdata_i[CFG_LEAD_LSB +: 2];
        cfg_lag  <= wdata_i[CFG_LAG_LSB +: 2];
        cfg_sdod <= wdata_i[CFG_SDOD_BIT];
        cfg_scod <= wdata_i[CFG_SCOD_BIT];
      end
      if (wr_mode) mode_half <= wdata_i[DIV_W-1:0];
      for (int i = 0; i < NSLV; i++) begin
        if (wr_en_i && addr_i == ADDR_W'(OFF_SLV0 + 4 * i)) begin
          slv_rdf[i] <= wdata_i[0];
          slv_wrf[i] <= wdata_i[1];
        end
      end
    end
  end

  // transfer settings captured at start, held for the whole transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_last <= '0;
      ctrl_rd   <= 1'b0;
      a_tgt     <= '0;
      a_lead    <= '0;
      a_lag     <= '0;
      a_half    <= '0;
      a_rdf     <= 1'b0;
      a_wrf     <= 1'b0;
    end else if (start) begin
      ctrl_last <= wdata_i[CNT_W-1:0];
      ctrl_rd   <= wdata_i[CTRL_RD_BIT];
      a_tgt     <= cfg_tgt;
      a_lead    <= cfg_lead;
      a_lag     <= cfg_lag;
      a_half    <= mode_half;
      a_rdf     <= rdf_pick;
      a_wrf     <= wrf_pick;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done && ctrl_rd;
      if (done_q)      buf_q <= rx;
      else if (wr_buf) buf_q <= wdata_i[DATA_W-1:0];
    end
  end

  sbm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(busy), .half_i(a_half), .tick_o(tick)
  );

  sbm_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i    (clk_i),    .rst_ni (rst_ni),  .start_i(start),  .tick_i(tick),
    .lead_i   (a_lead),   .lag_i  (a_lag),   .last_i (ctrl_last),
    .busy_o   (busy),     .run_o  (run),     .sclk_o (sclk_q),
    .rise_o   (rise),     .fall_o (fall),    .launch0_o(launch0), .done_o(done)
  );

  sbm_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk_i    (clk_i),    .rst_ni   (rst_ni),   .load_i   (start),
    .tx_data_i(buf_q),    .last_i   (wdata_i[CNT_W-1:0]),
    .rise_i   (rise),     .fall_i   (fall),     .launch0_i(launch0),
    .wr_fall_i(a_wrf),    .rd_fall_i(a_rdf),    .sdi_i    (sdio_i),
    .out_bit_o(out_bit),  .rx_o     (rx)
  );

  for (genvar i = 0; i < NSLV; i++) begin : g_ss
    assign ss_n_o[i] = !(busy && a_tgt == SEL_W'(i));
  end

  assign sclk_o    = !cfg_scod && sclk_q;
  assign sclk_oe_o = !cfg_scod || !sclk_q;
  assign sdio_o    = !cfg_sdod && out_bit;
  assign sdio_oe_o = run && !ctrl_rd && (!cfg_sdod || !out_bit);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CFG)) begin
      rdata_o[SEL_W-1:0]          = cfg_tgt;
      rdata_o[CFG_LEAD_LSB +: 2]  = cfg_lead;
      rdata_o[CFG_LAG_LSB +: 2]   = cfg_lag;
      rdata_o[CFG_SDOD_BIT]       = cfg_sdod;
      rdata_o[CFG_SCOD_BIT]       = cfg_scod;
    end
    if (addr_i == ADDR_W'(OFF_CTRL)) begin
      rdata_o[CNT_W-1:0]   = ctrl_last;
      rdata_o[CTRL_RD_BIT] = ctrl_rd;
    end
    if (addr_i == ADDR_W'(OFF_MODE)) rdata_o[DIV_W-1:0]  = mode_half;
    if (addr_i == ADDR_W'(OFF_STAT)) rdata_o[0]          = busy;
    if (addr_i == ADDR_W'(OFF_BUF))  rdata_o[DATA_W-1:0] = buf_q;
    for (int i = 0; i < NSLV; i++) begin
      if (addr_i == ADDR_W'(OFF_SLV0 + 4 * i)) rdata_o[1:0] = {slv_wrf[i], slv_rdf[i]};
    end
  end

  p_ss_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ss_n_o));
  p_reserved_none_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && a_tgt >= SEL_W'(NSLV)) |-> (&ss_n_o));
  p_rd_no_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && ctrl_rd) |-> !sdio_oe_o);
  p_sdio_od_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_sdod |-> !(sdio_oe_o && sdio_o));
  p_sclk_od_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_scod |-> !(sclk_oe_o && sclk_o));
  p_clk_in_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> busy);
  p_ctrl_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_ctrl) |=> $stable(ctrl_last) && $stable(ctrl_rd));
endmodule

// File: tb/sbm_master_tb.sv
module sbm_master_tb;
  import sbm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk_o, sclk_oe, sdio_o, sdio_oe, sdio_i;
  logic [1:0]  ss_n;

  always #10 clk = ~clk;

  sbm_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe), .sdio_o(sdio_o),
    .sdio_oe_o(sdio_oe), .sdio_i(sdio_i), .ss_n_o(ss_n)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit fin = 0;

  // slave model and line resolution with pull-ups
  logic        slv_drv = 1'b0;
  logic [31:0] slv_word = '0;
  int          slv_idx = 0, n_bits = 1;
  logic        sclk_l, sdio_l, slv_bit, sel_now;
  assign slv_bit = (slv_idx < n_bits) ? slv_word[n_bits-1-slv_idx] : 1'b1;
  assign sclk_l  = sclk_oe ? sclk_o : 1'b1;
  assign sdio_l  = sdio_oe ? sdio_o : (slv_drv ? slv_bit : 1'b1);
  assign sdio_i  = sdio_l;
  assign sel_now = ~&ss_n;

  bit rd_m, rdf_m, wrf_m, od_m, scod_m, tval_m;
  int P = 4, rises, t_sel, t_rise1, t_prise, t_fall, t_rel, sel_idx;
  bit per_bad, oe_bad, od_bad, scod_bad, idle_bad, seen_sel, two_sel;
  logic [31:0] cap;
  logic prev_sclk = 1'b0, prev_sel = 1'b0, prev_sdio = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sel_now && !prev_sel) begin t_sel = cyc; seen_sel = 1; sel_idx = ss_n[0] ? 1 : 0; end
    if (!sel_now && prev_sel) t_rel = cyc;
    if (ss_n == 2'b00) two_sel = 1;
    if (sclk_l && !prev_sclk) begin
      rises++;
      if (rises == 1) t_rise1 = cyc;
      else if (cyc - t_prise != P) per_bad = 1;
      t_prise = cyc;
      if (wrf_m) cap = {cap[30:0], prev_sdio};
      if (!rdf_m) slv_idx++;
    end
    if (!sclk_l && prev_sclk) begin
      t_fall = cyc;
      if (!wrf_m) cap = {cap[30:0], prev_sdio};
      if (rdf_m) slv_idx++;
    end
    if (rd_m && sdio_oe) oe_bad = 1;
    if (od_m && sdio_oe && sdio_o) od_bad = 1;
    if (scod_m && sclk_oe && sclk_o) scod_bad = 1;
    if (scod_m && !sclk_oe && !u_dut_sclk_high()) scod_bad = 1;
    if (tval_m && sclk_l && !sel_now) idle_bad = 1;
    prev_sclk = sclk_l;
    prev_sel  = sel_now;
    prev_sdio = sdio_l;
  end

  // with open drain the pin is released only while the clock should be high:
  // observed at the port, a released pin must coincide with a high resolved clock
  function automatic bit u_dut_sclk_high();
    return sclk_l;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 8'(a);
    #1 d = rdata;
  endtask

  function automatic logic [31:0] msk(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic xfer(input int tgt, input int lead, input int lag, input int half, input int n,
                      input bit rd, input bit rdf, input bit wrf, input bit sdod, input bit scod,
                      input logic [31:0] data, input bit poke);
    logic [31:0] d, ctrl;
    reg_wr(OFF_CFG, 32'(tgt) | 32'(lead << 3) | 32'(lag << 5) | 32'(sdod << 8) | 32'(scod << 9));
    reg_wr(OFF_MODE, 32'(half));
    reg_wr(OFF_SLV0, (tgt == 0) ? {30'b0, wrf, rdf} : {30'b0, ~wrf, ~rdf});
    reg_wr(OFF_SLV0 + 4, (tgt == 1) ? {30'b0, wrf, rdf} : {30'b0, ~wrf, ~rdf});
    reg_wr(OFF_BUF, rd ? 32'h0 : data);
    @(negedge clk);
    n_bits = n; rd_m = rd; rdf_m = rdf; wrf_m = wrf; od_m = sdod; scod_m = scod;
    tval_m = (tgt < 2); P = 2 * (half + 1);
    slv_word = data; slv_idx = 0; slv_drv = rd;
    rises = 0; cap = '0; t_sel = 0; t_rise1 = 0; t_fall = 0; t_rel = 0; sel_idx = -1;
    per_bad = 0; oe_bad = 0; od_bad = 0; scod_bad = 0; idle_bad = 0; seen_sel = 0; two_sel = 0;
    ctrl = 32'(n - 1) | (32'(rd) << 8);
    reg_wr(OFF_CTRL, ctrl);
    reg_rd(OFF_STAT, d);
    chk(d[0] == 1'b1, "R9 busy after start", d, 1);
    if (poke) begin
      reg_wr(OFF_CTRL, 32'h0000_0102 ^ ctrl);
      reg_rd(OFF_CTRL, d);
      chk(d == ctrl, "R9 control write while busy ignored", d, ctrl);
    end
    do reg_rd(OFF_STAT, d); while (d[0]);
    repeat (2) @(negedge clk);
    slv_drv = 1'b0;
    chk(rises == n, "R6 clock pulse count", rises, n);
    chk(!per_bad, "R6 clock period", P, P);
    chk(!idle_bad, "R6 clock low without select", 1, 0);
    chk(!two_sel, "R3 single select", 0, 0);
    if (tgt < 2) begin
      chk(seen_sel && sel_idx == tgt, "R3 select matches code", sel_idx, tgt);
      chk(t_rise1 - t_sel == (lead + 1) * P + P / 2, "R4 lead distance",
          t_rise1 - t_sel, (lead + 1) * P + P / 2);
      chk(t_rel - t_fall == (lag + 1) * P, "R5 lag distance", t_rel - t_fall, (lag + 1) * P);
    end else begin
      chk(!seen_sel, "R3 reserved code asserts no select", seen_sel, 0);
    end
    if (rd) begin
      reg_rd(OFF_BUF, d);
      chk(d == (data & msk(n)), "R8 read data right-aligned", d, data & msk(n));
      chk(!oe_bad, "R8 no drive during read", 1, 0);
    end else if (tgt < 2) begin
      chk((cap & msk(n)) == (data & msk(n)), "R7 write bits MSB first", cap & msk(n), data & msk(n));
    end
    if (sdod) chk(!od_bad, "R10 data open-drain never high", 1, 0);
    if (scod) chk(!scod_bad, "R11 clock open-drain never high", 1, 0);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ss_n == 2'b11, "R1 selects idle", ss_n, 2'b11);
    chk(sclk_oe && !sclk_o, "R1 clock driven low", {sclk_oe, sclk_o}, 2'b10);
    chk(!sdio_oe, "R1 data undriven", sdio_oe, 0);
    reg_rd(OFF_STAT, d); chk(d == 0, "R1 status zero", d, 0);
    reg_rd(OFF_BUF, d);  chk(d == 0, "R1 buffer zero", d, 0);

    // R2 register map readback with masks
    reg_wr(OFF_CFG, 32'hFFFF_FFFF);  reg_rd(OFF_CFG, d);  chk(d == 32'h37F, "R2 config", d, 32'h37F);
    reg_wr(OFF_MODE, 32'hFFFF_FFFF); reg_rd(OFF_MODE, d); chk(d == 32'hFF, "R2 mode", d, 32'hFF);
    reg_wr(OFF_SLV0, 32'hFFFF_FFFE); reg_rd(OFF_SLV0, d); chk(d == 32'h2, "R2 slave 0", d, 2);
    reg_wr(OFF_SLV0 + 4, 32'h1);     reg_rd(OFF_SLV0 + 4, d); chk(d == 32'h1, "R2 slave 1", d, 1);
    reg_wr(OFF_BUF, 32'hDEAD_BEEF);  reg_rd(OFF_BUF, d);  chk(d == 32'hDEAD_BEEF, "R2 buffer", d, 32'hDEAD_BEEF);
    reg_rd(32'h0C, d); chk(d == 0, "R2 unmapped offset", d, 0);
    reg_wr(OFF_CFG, 0); reg_wr(OFF_MODE, 0);

    // R4 R5: lead, lag and divisor sweep
    for (int half = 0; half < 3; half++)
      for (int lead = 0; lead < 4; lead++)
        for (int lag = 0; lag < 4; lag++)
          xfer(lead % 2, lead, lag, half, 8, 1'b0, lag[0], lead[1], 1'b0, 1'b0,
               32'h9E37_79B9 * 32'(half * 16 + lead * 4 + lag + 1), 1'b0);

    // R7 R8: edges, direction and bit count per slave
    for (int tgt = 0; tgt < 2; tgt++)
      for (int e = 0; e < 4; e++)
        for (int rd = 0; rd < 2; rd++)
          foreach (u_cnt[k])
            xfer(tgt, 0, 0, 1, u_cnt[k], rd[0], e[0], e[1], 1'b0, 1'b0,
                 32'hC3A5_96E1 ^ (32'h0101_0101 * 32'(tgt * 8 + e * 2 + rd)), 1'b0);

    // R10 R11: open-drain combinations
    for (int od = 0; od < 4; od++)
      for (int rd = 0; rd < 2; rd++)
        xfer(od % 2, 1, 1, 0, 12, rd[0], od[1], od[0], od[0], od[1], 32'h0000_0A5C ^ 32'(od * 97), 1'b0);

    // R3: reserved codes
    for (int tgt = 2; tgt < 8; tgt++)
      xfer(tgt, 0, 0, 0, 4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h5, 1'b0);

    // R9: control write during transfer
    xfer(0, 2, 1, 2, 16, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_B00F, 1'b1);
    xfer(1, 1, 2, 1, 10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_02D3, 1'b1);

    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int u_cnt[3] = '{1, 7, 32};

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL R9 watchdog act=hung exp=idle");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule